// File: doc/BRIEF.md
# Programmable Split-Phase Clock Prescaler

This block derives a slow conversion clock from the system clock. The high phase and the low phase of the derived clock are programmed on their own: a 5-bit high count and a 3-bit low count. One down counter times both phases. A zero detector ends the high phase. The counter then runs on through its wrap from zero to all ones. A complement comparator on the counter's low bits ends the low phase.

Besides the clock level, the block gives a one-cycle strobe on the first system cycle of each high phase and a one-cycle strobe on the first system cycle of each low phase. A conversion sequencer can use these strobes as clock enables, so it never has to detect edges of a derived clock.

Both phase counts are taken only when a new period starts. The low count is held in a latch for the period. Reset and disable park the output low. The next enable starts a fresh period from the current counts.

Top module: `clk_split_prescaler`

## Requirements
- R1: While `rst_n` is low, or one cycle after `enable` is sampled low, `clk_out`, `rise_stb` and `fall_stb` are all 0, and they stay 0 until `enable` is sampled high again.
- R2: Each high phase (`clk_out` = 1) lasts exactly `hi_cnt` + 1 system cycles, where `hi_cnt` is an unsigned 5-bit value from 0 to 31.
- R3: Each low phase (`clk_out` = 0) between two high phases lasts exactly `lo_cnt` + 1 system cycles, where `lo_cnt` is an unsigned 3-bit value from 0 to 7.
- R4: The output period is `hi_cnt` + `lo_cnt` + 2 system cycles. The first high cycle comes one clock after `enable` is first sampled high.
- R5: Both counts are sampled only on the clock edge that starts a high phase. A change partway through a period leaves that period unchanged and takes effect from the next period.
- R6: `rise_stb` is 1 only on the first cycle of every high phase, for exactly one cycle.
- R7: `fall_stb` is 1 only on the first cycle of every low phase, for exactly one cycle. `rise_stb` and `fall_stb` are never 1 together.
- R8: With both counts at 0 the output divides by 2 with one high cycle and one low cycle.
- R9: After a disable or reset that cuts a period short, re-enabling starts a complete high phase of the current `hi_cnt` + 1 cycles.
- R10: With the largest counts (31 and 7) the high phase is 32 cycles and the low phase 8 cycles, which needs the counter wrap from 0 to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the prescaler while high |
| hi_cnt | input | 5 | High-phase count; the high phase is this value + 1 cycles |
| lo_cnt | input | 3 | Low-phase count; the low phase is this value + 1 cycles |
| clk_out | output | 1 | Divided clock level |
| rise_stb | output | 1 | One-cycle strobe on the first high cycle |
| fall_stb | output | 1 | One-cycle strobe on the first low cycle |

## Verification
The hardest case to reach is a change to the counts while a period is running. The phase lengths only show the change if its effect is held back until the next reload. The bench writes new counts on the first high cycle of a long period. It then measures that period and the one after it separately. A second hard case is a disable in the middle of a phase followed by re-enabling with different counts. This shows whether stale counter contents leak into the restarted period.

// File: rtl/clk_split_pkg.sv
// Package: shared types for the split-phase prescaler.
// Assumes nothing beyond IEEE 1800-2017 enums.
package clk_split_pkg;

    // Phase of the divided clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

endpackage

// File: rtl/phase_down_counter.sv
// Module: phase_down_counter
// Shared down counter that times both phases. Clear has priority over load,
// and load has priority over decrement. Decrementing zero wraps to all ones.
// Assumes a synchronous active-low reset.
module phase_down_counter #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_q;

    // Count register: clear, load or decrement (with wrap) once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/phase_end_detect.sv
// Module: phase_end_detect
// Combinational end-of-phase detectors. The high phase ends when the
// whole counter is zero. The low phase ends when each of the counter's low
// LW bits is the inverse of the matching bit of the latched low count.
// Assumes LW <= CW.
module phase_end_detect #(
    parameter int CW = 5,
    parameter int LW = 3
) (
    input  logic [CW-1:0] cnt,
    input  logic [LW-1:0] lo_lat,
    output logic          hi_done,
    output logic          lo_done
);

    logic [LW-1:0] bit_match;

    // One inverted-match cell for each low-count bit.
    for (genvar i = 0; i < LW; i++) begin : g_cmp
        assign bit_match[i] = cnt[i] ^ lo_lat[i];
    end

    // Zero detector and reduction of the match cells.
    always_comb begin
        hi_done = (cnt == '0);
        lo_done = &bit_match;
    end

endmodule

// File: rtl/phase_sequencer.sv
// Module: phase_sequencer
// Phase state machine. It steers the shared counter, latches the low count
// at each reload and registers the clock level and both edge strobes.
// Assumes the detector flags refer to the counter value of the current cycle.
module phase_sequencer
    import clk_split_pkg::*;
#(
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          hi_done,
    input  logic          lo_done,
    input  logic [LW-1:0] lo_in,
    output logic          cnt_clr,
    output logic          cnt_load,
    output logic          cnt_dec,
    output logic [LW-1:0] lo_lat,
    output logic          clk_out,
    output logic          rise_stb,
    output logic          fall_stb
);

    phase_e        phase_q, phase_d;
    logic [LW-1:0] lo_q;
    logic          clk_q, rise_q, fall_q;
    logic          enter_low;

    // Next phase and counter controls.
    always_comb begin
        phase_d   = phase_q;
        cnt_clr   = 1'b0;
        cnt_load  = 1'b0;
        cnt_dec   = 1'b0;
        enter_low = 1'b0;
        if (!enable) begin
            phase_d = PH_IDLE;
            cnt_clr = 1'b1;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    phase_d  = PH_HIGH;
                    cnt_load = 1'b1;
                end
                PH_HIGH: begin
                    cnt_dec = 1'b1;
                    if (hi_done) begin
                        phase_d   = PH_LOW;
                        enter_low = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (lo_done) begin
                        phase_d  = PH_HIGH;
                        cnt_load = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                default: begin
                    phase_d = PH_IDLE;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Low-count latch, updated only on a reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (cnt_load) begin
            lo_q <= lo_in;
        end
    end

    // Registered clock level and edge strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q  <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            clk_q  <= (phase_d == PH_HIGH);
            rise_q <= cnt_load;
            fall_q <= enter_low;
        end
    end

    assign lo_lat   = lo_q;
    assign clk_out  = clk_q;
    assign rise_stb = rise_q;
    assign fall_stb = fall_q;

endmodule

// File: rtl/clk_split_prescaler.sv
// Module: clk_split_prescaler (top)
// Divides the system clock into a clock with separately programmed high and
// low phases, plus one-cycle rise and fall strobes. Assumes LO_W <= HI_W, so
// that the counter wrap gives all ones in the bits the comparator checks.
module clk_split_prescaler #(
    parameter int HI_W = 5,
    parameter int LO_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [HI_W-1:0] hi_cnt,
    input  logic [LO_W-1:0] lo_cnt,
    output logic            clk_out,
    output logic            rise_stb,
    output logic            fall_stb
);

    logic [HI_W-1:0] cnt;
    logic [LO_W-1:0] lo_lat;
    logic            cnt_clr, cnt_load, cnt_dec;
    logic            hi_done, lo_done;

    phase_down_counter #(.CW(HI_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .load     (cnt_load),
        .load_val (hi_cnt),
        .dec      (cnt_dec),
        .cnt      (cnt)
    );

    phase_end_detect #(.CW(HI_W), .LW(LO_W)) u_det (
        .cnt     (cnt),
        .lo_lat  (lo_lat),
        .hi_done (hi_done),
        .lo_done (lo_done)
    );

    phase_sequencer #(.LW(LO_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .hi_done  (hi_done),
        .lo_done  (lo_done),
        .lo_in    (lo_cnt),
        .cnt_clr  (cnt_clr),
        .cnt_load (cnt_load),
        .cnt_dec  (cnt_dec),
        .lo_lat   (lo_lat),
        .clk_out  (clk_out),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

endmodule

// File: rtl/clk_split_prescaler_chk.sv
// Module: clk_split_prescaler_chk
// Port-level checker for clk_split_prescaler. It measures the run length of
// each phase with counters and compares it with the counts sampled at reload.
module clk_split_prescaler_chk #(
    parameter int HI_W = 5,
    parameter int LO_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic [HI_W-1:0] hi_cnt,
    input logic [LO_W-1:0] lo_cnt,
    input logic            clk_out,
    input logic            rise_stb,
    input logic            fall_stb
);

    localparam int RW = HI_W + 3;

    logic [HI_W-1:0] hi_prev, hi_exp;
    logic [LO_W-1:0] lo_prev, lo_exp;
    logic [RW-1:0]   hi_run, lo_run;
    logic            low_valid;

    // Track the sampled counts and the run length of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_prev   <= '0;
            lo_prev   <= '0;
            hi_exp    <= '0;
            lo_exp    <= '0;
            hi_run    <= '0;
            lo_run    <= '0;
            low_valid <= 1'b0;
        end else begin
            hi_prev <= hi_cnt;
            lo_prev <= lo_cnt;
            if (rise_stb) begin
                hi_exp <= hi_prev;
                lo_exp <= lo_prev;
                hi_run <= RW'(1);
            end else if (clk_out) begin
                hi_run <= hi_run + RW'(1);
            end
            if (fall_stb) begin
                lo_run <= RW'(1);
            end else if (!clk_out) begin
                lo_run <= lo_run + RW'(1);
            end
            if (!enable) begin
                low_valid <= 1'b0;
            end else if (fall_stb) begin
                low_valid <= 1'b1;
            end
        end
    end

    // R1
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!clk_out && !rise_stb && !fall_stb));

    // R2
    high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (hi_run == RW'(hi_exp) + RW'(1)));

    // R3
    low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb && low_valid) |-> (lo_run == RW'(lo_exp) + RW'(1)));

    // R6
    rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (clk_out && !$past(clk_out)));

    // R6
    rise_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> rise_stb);

    // R7
    fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (!clk_out && $past(clk_out)));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

endmodule

bind clk_split_prescaler clk_split_prescaler_chk #(.HI_W(HI_W), .LO_W(LO_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .hi_cnt   (hi_cnt),
    .lo_cnt   (lo_cnt),
    .clk_out  (clk_out),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
);

// File: tb/clk_split_prescaler_tb_top.sv
// Bench for clk_split_prescaler: a table of counts walked by one loop, then
// directed tests for reset, disable, mid-period changes and restart.
module clk_split_prescaler_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [4:0] hi_cnt = '0;
    logic [2:0] lo_cnt = '0;
    logic       clk_out, rise_stb, fall_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Columns: hi, lo, expected high length, expected low length.
    localparam int NV = 8;
    localparam int VEC [NV][4] = '{
        '{11, 7, 12, 8},
        '{ 7, 7,  8, 8},
        '{ 0, 0,  1, 1},
        '{31, 7, 32, 8},
        '{ 0, 7,  1, 8},
        '{31, 0, 32, 1},
        '{ 3, 5,  4, 6},
        '{20, 2, 21, 3}
    };

    always #4 clk = ~clk;

    clk_split_prescaler dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .hi_cnt   (hi_cnt),
        .lo_cnt   (lo_cnt),
        .clk_out  (clk_out),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge showing the first high cycle; returns at the next one.
    task automatic measure(output int hl, output int ll, output int stb_bad);
        hl = 0;
        ll = 0;
        stb_bad = 0;
        while (clk_out && hl < 100) begin
            if (rise_stb != (hl == 0) || fall_stb) stb_bad++;
            hl++;
            @(negedge clk);
        end
        while (!clk_out && ll < 100) begin
            if (fall_stb != (ll == 0) || rise_stb) stb_bad++;
            ll++;
            @(negedge clk);
        end
    endtask

    task automatic start(input int h, input int l);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        hi_cnt = 5'(h);
        lo_cnt = 3'(l);
        enable = 1'b1;
        @(negedge clk);
    endtask

    // Stop a hung run and count it as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hl, ll, sb;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset clk_out", int'(clk_out), 0);
        check("R1 reset strobes", int'(rise_stb | fall_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle clk_out", int'(clk_out), 0);

        // Table walk: R2, R3, R4, R6, R7, R8, R10
        for (int i = 0; i < NV; i++) begin
            start(VEC[i][0], VEC[i][1]);
            check("R4 first rise latency", int'(rise_stb & clk_out), 1);
            for (int p = 0; p < 2; p++) begin
                measure(hl, ll, sb);
                check("R2 high length", hl, VEC[i][2]);
                check("R3 low length", ll, VEC[i][3]);
                check("R4 period", hl + ll, VEC[i][0] + VEC[i][1] + 2);
                check("R6 R7 strobe placement", sb, 0);
            end
        end

        // R5: change counts on the first high cycle of a long period
        start(10, 5);
        hi_cnt = 5'd2;
        lo_cnt = 3'd1;
        measure(hl, ll, sb);
        check("R5 running high unchanged", hl, 11);
        check("R5 running low unchanged", ll, 6);
        measure(hl, ll, sb);
        check("R5 next high uses new", hl, 3);
        check("R5 next low uses new", ll, 2);

        // R1: disable partway through a high phase
        hi_cnt = 5'd20;
        lo_cnt = 3'd4;
        measure(hl, ll, sb);
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            check("R1 disabled outputs", int'({clk_out, rise_stb, fall_stb}), 0);
            @(negedge clk);
        end

        // R9: restart with new counts gives a full high phase
        hi_cnt = 5'd6;
        lo_cnt = 3'd3;
        enable = 1'b1;
        @(negedge clk);
        check("R9 restart rise", int'(rise_stb), 1);
        measure(hl, ll, sb);
        check("R9 restart high", hl, 7);
        check("R9 restart low", ll, 4);

        // R1, R9: reset partway through a low phase, then resume
        hi_cnt = 5'd1;
        lo_cnt = 3'd7;
        measure(hl, ll, sb);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid low", int'({clk_out, rise_stb, fall_stb}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 rise after reset", int'(rise_stb), 1);
        measure(hl, ll, sb);
        check("R9 high after reset", hl, 2);
        check("R9 low after reset", ll, 8);

        // R8: divide-by-2 shows alternating levels
        start(0, 0);
        for (int k = 0; k < 6; k++) begin
            check("R8 alternating level", int'(clk_out), (k % 2 == 0) ? 1 : 0);
            @(negedge clk);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule